// File: doc/BRIEF.md
# Majority-Vote Strobe Sampler

This block settles the value of each byte lane's training status during strobe-delay calibration. The calibration algorithm moves a delay, then needs a trustworthy reading of whether the strobe sits before or after the edge. A single reading can be noisy, so the block takes a fixed number of readings per lane and keeps the majority.

The lanes are handled in pairs. Each pair is a group that shares one status word. For every group, in ascending order, the block runs a set number of rounds. In each round it asks an external memory-operation port for one test access over a request/acknowledge handshake, then captures the group's status word. The access is a read in receive-enable mode and a write in write-strobe mode. After the last round of a group, each lane of the pair gets its voted bit. When the last active group is decided, a one-cycle done pulse marks the result vector as ready.

In x16 channel width only half the lanes take part, so only the lower half of the groups are visited. The mode and the width are captured when a run starts.

Top module: `strobe_vote_sampler`

## Requirements
- R1: After reset, `mem_req`, `mem_first` and `done` are 0 and `lane_result` is all zeros.
- R2: Every round issues exactly one request. `mem_write` is 0 in receive-enable mode (`mode_wr`=0) and 1 in write-strobe mode (`mode_wr`=1). A full-width run makes SAMPLES requests per group, over NUM_LANES/2 groups.
- R3: `mem_first` is 1 on the first request after a start is accepted, and on no other request.
- R4: Once raised, `mem_req` stays high until `mem_ack` is seen, and `mem_group` and `mem_write` stay stable while it waits.
- R5: The status bit used depends on the mode. In receive-enable mode the even lane of a group (result bit 2g) uses status bit 1 and the odd lane (bit 2g+1) uses status bit 0. In write-strobe mode they use bits 9 and 8. All other status bits are ignored.
- R6: A lane's result is 1 only when its count of ones over the SAMPLES captured words is strictly greater than its count of zeros. A tie gives 0.
- R7: Groups are visited in ascending order, and `mem_group` shows the group under test on each request. Group g writes only result bits 2g and 2g+1.
- R8: With `wide_x16`=1 at start, only groups 0 to NUM_LANES/4-1 are visited and the upper half of `lane_result` stays 0.
- R9: `done` is high for exactly one cycle, the cycle after the last group's decision is stored. `lane_result` is valid in that cycle and holds until the next accepted start.
- R10: A `start` while a run is in progress is ignored. Changes to `mode_wr` and `wide_x16` after a start is accepted do not affect that run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sampling run (accepted only when idle) |
| mode_wr | input | 1 | 0 = receive-enable (read accesses), 1 = write-strobe (write accesses) |
| wide_x16 | input | 1 | 1 = x16 channel width, half the lanes active |
| mem_req | output | 1 | Test access request to the memory-operation port |
| mem_write | output | 1 | Access direction: 1 = write, 0 = read |
| mem_first | output | 1 | Marks the first access of a run |
| mem_group | output | GRP_W | Group under test |
| mem_ack | input | 1 | Access completed; the status word is valid from this cycle on |
| stat_word | input | 16 | Training status word of the group under test |
| lane_result | output | NUM_LANES | Voted bit per lane |
| done | output | 1 | One-cycle pulse: result ready |

## Verification
`mem_req` rises in the cycle after the edge that accepts `start`. The status word is captured on the clock edge that follows the acknowledged edge, so the bench holds `stat_word` for two edges. The decision for a group is stored two edges after its last acknowledged edge, and `done` and the final `lane_result` appear together in that cycle. The bench drives inputs on falling edges, checks each request's group, direction and first-access marking when it acknowledges it, and reads the result in the cycle where `done` is seen high. It confirms that `done` is low again one cycle later and that the result is unchanged a few cycles after that. Acknowledge latencies of zero and two cycles exercise the held request.

// File: rtl/svs_pkg.sv
package svs_pkg;

    localparam int STAT_W = 16;

    // status bit positions; lane pairs are decoded by the status source
    localparam int RCV_BIT_EVEN = 1;
    localparam int RCV_BIT_ODD  = 0;
    localparam int WR_BIT_EVEN  = 9;
    localparam int WR_BIT_ODD   = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_CAP,
        ST_DEC,
        ST_DONE
    } svs_state_t;

    typedef struct packed {
        logic odd;
        logic even;
    } lane_pair_t;

    typedef struct packed {
        logic wr;
        logic x16;
    } run_cfg_t;

    function automatic logic stat_bit(input logic [STAT_W-1:0] w,
                                      input logic wr, input logic odd);
        int pos;
        if (wr) pos = odd ? WR_BIT_ODD : WR_BIT_EVEN;
        else    pos = odd ? RCV_BIT_ODD : RCV_BIT_EVEN;
        return w[pos];
    endfunction

    function automatic logic maj_vote(input int ones, input int total);
        return (2 * ones) > total;
    endfunction

endpackage

// File: rtl/svs_sequencer.sv
module svs_sequencer
    import svs_pkg::*;
#(
    parameter int NUM_GROUPS = 2,
    parameter int SAMPLES    = 5,
    parameter int GRP_W      = 1,
    parameter int SCNT_W     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             mode_wr,
    input  logic             wide_x16,
    input  logic             mem_ack,
    output logic             mem_req,
    output logic             mem_write,
    output logic             mem_first,
    output logic [GRP_W-1:0] mem_group,
    output logic             cap_en,
    output logic             dec_en,
    output logic             tally_clr,
    output logic             res_clr,
    output logic             done
);

    localparam logic [GRP_W-1:0]  FULL_LAST = GRP_W'(NUM_GROUPS - 1);
    localparam logic [GRP_W-1:0]  HALF_LAST = GRP_W'(NUM_GROUPS / 2 - 1);
    localparam logic [SCNT_W-1:0] LAST_S    = SCNT_W'(SAMPLES - 1);

    svs_state_t        st;
    logic [SCNT_W-1:0] scnt;
    logic [GRP_W-1:0]  grp;
    logic              first_q;
    run_cfg_t          cfg;
    logic [GRP_W-1:0]  last_grp;

    assign last_grp = cfg.x16 ? HALF_LAST : FULL_LAST;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            scnt    <= '0;
            grp     <= '0;
            first_q <= 1'b0;
            cfg     <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st      <= ST_REQ;
                        scnt    <= '0;
                        grp     <= '0;
                        first_q <= 1'b1;
                        cfg.wr  <= mode_wr;
                        cfg.x16 <= wide_x16;
                    end
                end
                ST_REQ: begin
                    if (mem_ack) begin
                        st      <= ST_CAP;
                        first_q <= 1'b0;
                    end
                end
                ST_CAP: begin
                    if (scnt == LAST_S) begin
                        st   <= ST_DEC;
                        scnt <= '0;
                    end else begin
                        st   <= ST_REQ;
                        scnt <= scnt + 1'b1;
                    end
                end
                ST_DEC: begin
                    if (grp == last_grp) begin
                        st <= ST_DONE;
                    end else begin
                        st  <= ST_REQ;
                        grp <= grp + 1'b1;
                    end
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = (st == ST_REQ);
        mem_write = cfg.wr;
        mem_first = mem_req && first_q;
        mem_group = grp;
        cap_en    = (st == ST_CAP);
        dec_en    = (st == ST_DEC);
        done      = (st == ST_DONE);
        res_clr   = (st == ST_IDLE) && start;
        tally_clr = dec_en || res_clr;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_group) && $stable(mem_write))); // R4

    AST_FIRST_ONCE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> !mem_first); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_X16_RANGE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && cfg.x16) |-> (mem_group <= HALF_LAST)); // R8

endmodule

// File: rtl/svs_lane_tally.sv
module svs_lane_tally #(
    parameter int SAMPLES = 5,
    parameter int CNT_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic             bit_in,
    output logic [CNT_W-1:0] ones
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ones <= '0;
        end else if (en && bit_in) begin
            ones <= ones + 1'b1;
        end
    end

    AST_TALLY_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(ones) <= SAMPLES); // R6

endmodule

// File: rtl/svs_result_store.sv
module svs_result_store
    import svs_pkg::*;
#(
    parameter int NUM_GROUPS = 2,
    parameter int GRP_W      = 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    wr_en,
    input  logic [GRP_W-1:0]        grp,
    input  lane_pair_t              pair,
    output logic [2*NUM_GROUPS-1:0] result
);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                result[2*g +: 2] <= 2'b00;
            end else if (wr_en && (grp == GRP_W'(g))) begin
                result[2*g]   <= pair.even;
                result[2*g+1] <= pair.odd;
            end
        end
    end

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clr && !wr_en) |=> $stable(result)); // R9

endmodule

// File: rtl/strobe_vote_sampler.sv
module strobe_vote_sampler
    import svs_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int SAMPLES   = 5,
    localparam int NUM_GROUPS = NUM_LANES / 2,
    localparam int GRP_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
    localparam int SCNT_W     = (SAMPLES > 1) ? $clog2(SAMPLES) : 1,
    localparam int CNT_W      = $clog2(SAMPLES + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 mode_wr,
    input  logic                 wide_x16,
    output logic                 mem_req,
    output logic                 mem_write,
    output logic                 mem_first,
    output logic [GRP_W-1:0]     mem_group,
    input  logic                 mem_ack,
    input  logic [STAT_W-1:0]    stat_word,
    output logic [NUM_LANES-1:0] lane_result,
    output logic                 done
);

    logic       cap_en;
    logic       dec_en;
    logic       tally_clr;
    logic       res_clr;
    logic [1:0] lane_bit;
    logic [CNT_W-1:0] ones [2];
    lane_pair_t pair;

    svs_sequencer #(
        .NUM_GROUPS(NUM_GROUPS),
        .SAMPLES   (SAMPLES),
        .GRP_W     (GRP_W),
        .SCNT_W    (SCNT_W)
    ) seq_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .mode_wr  (mode_wr),
        .wide_x16 (wide_x16),
        .mem_ack  (mem_ack),
        .mem_req  (mem_req),
        .mem_write(mem_write),
        .mem_first(mem_first),
        .mem_group(mem_group),
        .cap_en   (cap_en),
        .dec_en   (dec_en),
        .tally_clr(tally_clr),
        .res_clr  (res_clr),
        .done     (done)
    );

    for (genvar l = 0; l < 2; l++) begin : g_lane
        assign lane_bit[l] = stat_bit(stat_word, mem_write, l[0]);

        svs_lane_tally #(
            .SAMPLES(SAMPLES),
            .CNT_W  (CNT_W)
        ) tally_i (
            .clk   (clk),
            .rst   (rst),
            .clr   (tally_clr),
            .en    (cap_en),
            .bit_in(lane_bit[l]),
            .ones  (ones[l])
        );
    end

    always_comb begin
        pair.even = maj_vote(int'(ones[0]), SAMPLES);
        pair.odd  = maj_vote(int'(ones[1]), SAMPLES);
    end

    svs_result_store #(
        .NUM_GROUPS(NUM_GROUPS),
        .GRP_W     (GRP_W)
    ) store_i (
        .clk   (clk),
        .rst   (rst),
        .clr   (res_clr),
        .wr_en (dec_en),
        .grp   (mem_group),
        .pair  (pair),
        .result(lane_result)
    );

    AST_REQ_IDLE_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_req); // R2

    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        (mem_req && start) |=> !mem_first); // R10

endmodule

// File: tb/strobe_vote_sampler_tb_top.sv
module strobe_vote_sampler_tb_top;

    localparam int LANES = 4;
    localparam int NS    = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        mode_wr = 1'b0;
    logic        wide_x16 = 1'b0;
    logic        mem_req;
    logic        mem_write;
    logic        mem_first;
    logic [0:0]  mem_group;
    logic        mem_ack = 1'b0;
    logic [15:0] stat_word = 16'h0;
    logic [3:0]  lane_result;
    logic        done;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    strobe_vote_sampler #(.NUM_LANES(LANES), .SAMPLES(NS)) dut_i (
        .clk(clk), .rst(rst), .start(start), .mode_wr(mode_wr),
        .wide_x16(wide_x16), .mem_req(mem_req), .mem_write(mem_write),
        .mem_first(mem_first), .mem_group(mem_group), .mem_ack(mem_ack),
        .stat_word(stat_word), .lane_result(lane_result), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] word_of(input int kind, input int seed,
                                            input int g, input int s);
        logic [15:0] w;
        logic [31:0] h;
        w = 16'h0;
        case (kind)
            0: w = 16'h0102;
            1: begin
                w[1] = (s < 3);
                w[0] = (s < 2);
                w[9] = (s >= 3);
                w[8] = (s >= 2);
            end
            default: begin
                h = (32'(seed) * 32'h9E3779B1) ^ (32'(g) * 32'h85EBCA6B)
                    ^ (32'(s) * 32'hC2B2AE35);
                h = h ^ (h >> 15);
                h = h * 32'h2C1B3C6D;
                w = h[15:0] ^ h[31:16];
            end
        endcase
        return w;
    endfunction

    function automatic logic [3:0] expect_res(input int kind, input int seed,
                                              input bit wr, input bit x16);
        logic [3:0] r;
        int pos;
        int cnt;
        r = 4'h0;
        for (int g = 0; g < (x16 ? 1 : 2); g++) begin
            for (int l = 0; l < 2; l++) begin
                // receive: even lane bit1, odd lane bit0; write: bits 9 and 8
                pos = wr ? (l == 0 ? 9 : 8) : (l == 0 ? 1 : 0);
                cnt = 0;
                for (int s = 0; s < NS; s++) begin
                    logic [15:0] w;
                    w = word_of(kind, seed, g, s);
                    if (w[pos]) cnt++;
                end
                r[2*g+l] = (cnt > NS - cnt);
            end
        end
        return r;
    endfunction

    task automatic run_case(input string req, input int kind, input int seed,
                            input bit wr, input bit x16, input int lat,
                            input bit poke);
        int nreq = 0;
        int exp_req;
        int cyc = 0;
        int waitc = 0;
        int grp_err = 0;
        int wr_err = 0;
        int first_err = 0;
        bit poked = 0;
        bit got_done = 0;
        logic [3:0] exp_r;
        logic [3:0] held;
        exp_req = (x16 ? 1 : 2) * NS;
        exp_r = expect_res(kind, seed, wr, x16);
        @(negedge clk);
        mode_wr = wr;
        wide_x16 = x16;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        mode_wr = ~wr;      // R10: late change must not matter
        wide_x16 = ~x16;
        while (cyc < 2000) begin
            if (done) begin
                got_done = 1;
                break;
            end
            start = 1'b0;
            if (poke && nreq == 3 && !poked && !mem_ack) begin
                start = 1'b1;   // R10: start while busy
                poked = 1;
            end
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (waitc < lat) begin
                    waitc++;
                end else begin
                    waitc = 0;
                    if (int'(mem_group) != nreq / NS) grp_err++;
                    if (mem_write != wr) wr_err++;
                    if (mem_first != (nreq == 0)) first_err++;
                    stat_word = word_of(kind, seed, nreq / NS, nreq % NS);
                    mem_ack = 1'b1;
                    nreq++;
                end
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(got_done, req, "done seen", 32'(got_done), 1);
        chk(lane_result == exp_r, req, "lane_result", 32'(lane_result), 32'(exp_r));
        chk(grp_err == 0, "R7", "group order errors", grp_err, 0);
        chk(wr_err == 0, "R2", "direction errors", wr_err, 0);
        chk(first_err == 0, "R3", "first-access errors", first_err, 0);
        chk(nreq == exp_req, x16 ? "R8" : "R2", "request count", nreq, exp_req);
        held = lane_result;
        @(negedge clk);
        chk(!done, "R9", "done one cycle", 32'(done), 0);
        repeat (3) @(negedge clk);
        chk(lane_result == held, "R9", "result held", 32'(lane_result), 32'(held));
        chk(!mem_req, "R9", "idle after done", 32'(mem_req), 0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!mem_req && !mem_first, "R1", "req/first after reset",
            32'({mem_req, mem_first}), 0);
        chk(!done, "R1", "done after reset", 32'(done), 0);
        chk(lane_result == 4'h0, "R1", "result after reset", 32'(lane_result), 0);
    endtask

    task automatic t_select;
        run_case("R5", 0, 0, 1'b0, 1'b0, 0, 1'b0);   // expect 0101
        run_case("R5", 0, 0, 1'b1, 1'b0, 0, 1'b0);   // expect 1010
    endtask

    task automatic t_boundary;
        run_case("R6", 1, 0, 1'b0, 1'b0, 0, 1'b0);   // 3 of 5 vs 2 of 5
        run_case("R6", 1, 0, 1'b1, 1'b0, 2, 1'b0);
    endtask

    task automatic t_random;
        for (int i = 1; i <= 6; i++) begin
            run_case("R6", 2, i * 17 + 3, i[0], 1'b0, i % 3, 1'b0);
        end
    endtask

    task automatic t_x16;
        run_case("R8", 0, 0, 1'b0, 1'b1, 0, 1'b0);   // expect 0001
        run_case("R8", 2, 99, 1'b1, 1'b1, 1, 1'b0);
    endtask

    task automatic t_busy_start;
        run_case("R10", 2, 41, 1'b0, 1'b0, 0, 1'b1);
        run_case("R4", 2, 77, 1'b1, 1'b0, 2, 1'b1);
    endtask

    initial begin
        t_reset;
        t_select;
        t_boundary;
        t_random;
        t_x16;
        t_busy_start;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule